// File: doc/BRIEF.md
# Edge-Triggered Input Capture Unit

This block timestamps events on an external input. A 16-bit free-running counter advances once every four bus clocks. A two-flop synchronizer and an edge detector watch the input pin. When the edge chosen by software appears, the counter value is copied into a capture register. The copied value carries a fixed offset of one count, which accounts for the time the synchronizer takes.

A host with an 8-bit bus reads the capture register as two bytes. Reading the high byte freezes further transfers until the low byte has been read, so the two bytes always belong to the same event. A capture flag records that an edge has occurred. It is cleared by a read of the status register followed by a read of the capture low byte. The flag, gated by an enable bit, drives an interrupt request.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset the counter starts at 0 and increases by exactly one every 4 bus clocks, wrapping modulo 2^16. Two captures taken 4·n clocks apart therefore differ by n.
- R2: While reset is asserted and right after it, `rd_data` is 0, `cap_irq` is 0, the control register reads 0 and the status register reads 0.
- R3: Control bit 0 selects the edge. With the bit at 1, a 0-to-1 transition triggers a capture. With the bit at 0, a 1-to-0 transition triggers a capture. A transition of the other direction sets no flag and loads nothing.
- R4: On a qualifying edge the capture register loads C+1. C is the counter value held during the clock in which the new input level was first sampled. The register loads on every qualifying edge, even when the flag is already set, and the capture flag (status bit 0) becomes 1.
- R5: The flag is cleared only by a status read made while the flag is 1, followed later by a read of the capture low byte. A low-byte read without that earlier status read leaves the flag at 1. A new edge in the clearing cycle keeps the flag at 1.
- R6: A read of the capture high byte (offset 0x14) blocks capture transfers until the capture low byte (offset 0x15) is read. Edges that arrive while transfers are blocked are lost, but they still set the flag.
- R7: A transfer that falls in the same clock as a low-byte read is not blocked. The read returns the previous low byte, and the new value is visible afterwards.
- R8: The register map is: control at 0x12 (all bits read back as written), status at 0x13, capture high at 0x14, capture low at 0x15. A read strobed in one clock presents its data on `rd_data` after that clock edge and holds it until the next read. Unmapped offsets read 0, and writes to any offset other than 0x12 have no effect.
- R9: `cap_irq` equals the capture flag ANDed with control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_in | input | 1 | Asynchronous external event input |
| bus_addr | input | 5 | Register offset for reads and writes |
| rd_en | input | 1 | Read strobe, one clock per access |
| wr_en | input | 1 | Write strobe, one clock per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| cap_irq | output | 1 | Capture interrupt request |

## Verification
The hardest case to reach is a transfer that lands in exactly the clock of a low-byte read, while the interlock is still holding. It cannot be observed directly, because the edge only reaches the capture logic after the synchronizer stages. The stimulus therefore first sets the interlock with a high-byte read. It then changes the input level and issues the low-byte read so that the strobe is sampled two clocks after the first sampling edge. The value that follows must be the new timestamp. A companion case places edges inside a held interlock and checks that the old value survives while the flag still rises. Counter spacing is checked by placing two triggering transitions a multiple of four clocks apart.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  localparam int unsigned ADR_CTRL = 'h12;
  localparam int unsigned ADR_STAT = 'h13;
  localparam int unsigned ADR_CAPH = 'h14;
  localparam int unsigned ADR_CAPL = 'h15;
  localparam int unsigned CTL_EDGE_BIT = 0;
  localparam int unsigned CTL_IE_BIT   = 1;
endpackage

// File: rtl/ecu_timebase.sv
module ecu_timebase #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned DELAY    = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_late
);
  localparam int unsigned PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PS_W-1:0]  pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dly_q [DELAY];

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (pre_q == PS_W'(PRESCALE - 1)) begin
      pre_q <= '0;
      cnt_q <= cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // delay line keeps the counter aligned with the synchronizer latency
  generate
    for (genvar g = 0; g < DELAY; g++) begin : g_dly
      always_ff @(posedge clk) begin
        if (rst) dly_q[g] <= '0;
        else if (g == 0) dly_q[g] <= cnt_q;
        else dly_q[g] <= dly_q[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign cnt_late = dly_q[DELAY-1];
endmodule

// File: rtl/ecu_sync_edge.sv
module ecu_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic sel_rise,
  output logic edge_hit
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_hit = sel_rise ? ( sync_q[STAGES-1] & ~prev_q)
                             : (~sync_q[STAGES-1] &  prev_q);
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import ecu_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PRESCALE    = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              cap_irq
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  cnt_late;
  logic [CNT_W-1:0]  cap_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rd_next;
  logic              edge_hit;
  logic              lock_q, flag_q, arm_q;
  logic              hi_rd, lo_rd, st_rd, ct_wr, blocked, xfer;

  ecu_timebase #(.CNT_W(CNT_W), .PRESCALE(PRESCALE), .DELAY(SYNC_STAGES)) u_tb (
    .clk(clk), .rst(rst), .cnt_late(cnt_late)
  );

  ecu_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .din(cap_in),
    .sel_rise(ctrl_q[CTL_EDGE_BIT]), .edge_hit(edge_hit)
  );

  assign hi_rd = rd_en && (bus_addr == ADDR_W'(ADR_CAPH));
  assign lo_rd = rd_en && (bus_addr == ADDR_W'(ADR_CAPL));
  assign st_rd = rd_en && (bus_addr == ADDR_W'(ADR_STAT));
  assign ct_wr = wr_en && (bus_addr == ADDR_W'(ADR_CTRL));

  // a high-byte read in this clock also blocks, a low-byte read releases
  assign blocked = (lock_q | hi_rd) & ~lo_rd;
  assign xfer    = edge_hit & ~blocked;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (ct_wr) ctrl_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (xfer) cap_q <= cnt_late + 1'b1;
      if (hi_rd) lock_q <= 1'b1;
      else if (lo_rd) lock_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (lo_rd && arm_q) begin
        flag_q <= 1'b0;
        arm_q  <= 1'b0;
      end else if (st_rd && flag_q) begin
        arm_q <= 1'b1;
      end
      if (edge_hit) flag_q <= 1'b1;
    end
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(ADR_CTRL))      rd_next = ctrl_q;
    else if (bus_addr == ADDR_W'(ADR_STAT)) rd_next = DATA_W'(flag_q);
    else if (bus_addr == ADDR_W'(ADR_CAPH)) rd_next = cap_q[CNT_W-1:DATA_W];
    else if (bus_addr == ADDR_W'(ADR_CAPL)) rd_next = cap_q[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  assign cap_irq = flag_q & ctrl_q[CTL_IE_BIT];
endmodule

// File: rtl/ecu_checkers.sv
module ecu_timebase_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt_q
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt_q) |-> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R1
  AST_CNT_SPACING: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt_q) |=> $stable(cnt_q)); // R1
endmodule

module ecu_capture_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              edge_hit,
  input logic              lock_q,
  input logic              flag_q,
  input logic              cap_irq,
  input logic [CNT_W-1:0]  cap_q,
  input logic [CNT_W-1:0]  cnt_late
);
  logic lo_sel, hi_sel;
  assign lo_sel = rd_en && (bus_addr == ADDR_W'('h15));
  assign hi_sel = rd_en && (bus_addr == ADDR_W'('h14));

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !lo_sel) |=> $stable(cap_q)); // R6
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (edge_hit && !lock_q && !hi_sel) |=> cap_q == CNT_W'($past(cnt_late) + 1'b1)); // R4
  AST_FLAG_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    edge_hit |=> flag_q); // R4
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !lo_sel) |=> flag_q); // R5
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    cap_irq |-> flag_q); // R9
endmodule

bind ecu_timebase ecu_timebase_chk #(.CNT_W(CNT_W)) u_tb_chk (
  .clk(clk), .rst(rst), .cnt_q(cnt_q)
);

bind edge_capture_timer ecu_capture_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_cap_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .bus_addr(bus_addr),
  .edge_hit(edge_hit), .lock_q(lock_q), .flag_q(flag_q),
  .cap_irq(cap_irq), .cap_q(cap_q), .cnt_late(cnt_late)
);

// File: tb/edge_capture_timer_test.sv
`timescale 1ns/1ps
module edge_capture_timer_test;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int SYNC = 2;
  localparam int A_CTRL = 'h12, A_STAT = 'h13, A_CAPH = 'h14, A_CAPL = 'h15;

  logic clk = 0, rst = 1, cap_in = 0, rd_en = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_data;
  logic cap_irq;

  always #2 clk = ~clk;

  edge_capture_timer uut (
    .clk(clk), .rst(rst), .cap_in(cap_in), .bus_addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wdata), .rd_data(rd_data), .cap_irq(cap_irq)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit run_cmp = 0, done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  typedef struct { int due; bit rise; int val; } ev_t;
  ev_t evq[$];
  int m_cnt, m_pre, m_cap, m_rd, tick;
  bit m_lvl, m_lock, m_flag, m_arm;
  logic [7:0] m_ctrl;

  always @(posedge clk) begin : mdl
    bit hr, lr, sr, valid, nflag, narm;
    int vcap;
    ev_t e;
    cyc++;
    if (rst) begin
      m_cnt = 0; m_pre = 0; m_rd = 0; tick = 0; m_cap = 0;
      m_lvl = 0; m_lock = 0; m_flag = 0; m_arm = 0; m_ctrl = 0;
      evq.delete();
    end else begin
      hr = rd_en && addr == AW'(A_CAPH);
      lr = rd_en && addr == AW'(A_CAPL);
      sr = rd_en && addr == AW'(A_STAT);
      valid = 0; vcap = 0;
      if (evq.size() > 0 && evq[0].due == tick) begin
        e = evq.pop_front();
        if (e.rise == m_ctrl[0]) begin valid = 1; vcap = e.val; end
      end
      if (rd_en) begin
        if (addr == AW'(A_CTRL)) m_rd = m_ctrl;
        else if (sr) m_rd = m_flag;
        else if (hr) m_rd = (m_cap >> 8) & 8'hff;
        else if (lr) m_rd = m_cap & 8'hff;
        else m_rd = 0;
      end
      if (valid && !((m_lock || hr) && !lr)) m_cap = vcap;
      if (hr) m_lock = 1; else if (lr) m_lock = 0;
      nflag = m_flag; narm = m_arm;
      if (lr && m_arm) begin nflag = 0; narm = 0; end
      else if (sr && m_flag) narm = 1;
      if (valid) nflag = 1;
      m_flag = nflag; m_arm = narm;
      if (wr_en && addr == AW'(A_CTRL)) m_ctrl = wdata;
      if (cap_in != m_lvl) begin
        evq.push_back('{due: tick + SYNC, rise: cap_in, val: (m_cnt + 1) & 16'hffff});
        m_lvl = cap_in;
      end
      if (m_pre == 3) begin m_pre = 0; m_cnt = (m_cnt + 1) & 16'hffff; end
      else m_pre++;
      tick++;
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      check("R8 read data vs model", rd_data, m_rd);
      check("R9 irq vs model", cap_irq, m_flag & m_ctrl[1]);
    end
  end

  task automatic rd(input int a, output int v);
    @(negedge clk); rd_en = 1; addr = AW'(a);
    @(negedge clk); rd_en = 0; v = rd_data;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_in(input bit v);
    @(negedge clk); cap_in = v;
  endtask

  task automatic rd_cap(output int v);
    int h, l;
    rd(A_CAPH, h); rd(A_CAPL, l);
    v = (h << 8) | l;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int v, v1, v2, old, t1, t2;
    idle(4);
    check("R2 rd_data in reset", rd_data, 0);
    check("R2 irq in reset", cap_irq, 0);
    rst = 0;
    run_cmp = 1;
    rd(A_CTRL, v); check("R2 ctrl after reset", v, 0);
    rd(A_STAT, v); check("R2 status after reset", v, 0);

    // falling mode by default: rising ignored, falling captured
    drive_in(1); idle(6);
    rd(A_STAT, v); check("R3 rising ignored in falling mode", v, 0);
    drive_in(0); idle(6);
    rd(A_CAPL, v);
    rd(A_STAT, v); check("R5 low read alone keeps flag", v, 1);
    rd(A_CAPL, v);
    rd(A_STAT, v); check("R5 status then low clears flag", v, 0);
    rd_cap(v); check("R4 capture vs model", v, m_cap);

    // rising mode, counter spacing
    wr(A_CTRL, 1);
    drive_in(1); t1 = cyc; idle(6);
    rd(A_STAT, v); check("R3 rising captured in rising mode", v, 1);
    rd_cap(v1);
    drive_in(0); idle(3);
    do @(negedge clk); while (((cyc - t1) % 4) != 0 || (cyc - t1) < 60);
    cap_in = 1; t2 = cyc;
    idle(6);
    rd_cap(v2);
    check("R1 counter spacing", (v2 - v1) & 16'hffff, (t2 - t1) / 4);

    // reload while flag already set
    drive_in(0); idle(4); drive_in(1); idle(6);
    rd_cap(v);
    check("R4 reload with flag set", v != v2, 1);
    check("R4 reload value vs model", v, m_cap);
    old = v;

    // interlock holds old value, edge still flags
    rd(A_STAT, v); rd(A_CAPL, v);
    rd(A_CAPH, v); check("R6 high byte", v, (old >> 8) & 8'hff);
    drive_in(0); idle(4); drive_in(1); idle(8);
    rd(A_STAT, v); check("R6 blocked edge sets flag", v, 1);
    rd(A_CAPL, v); check("R6 low byte coherent", v, old & 8'hff);
    rd_cap(v); check("R6 blocked transfer lost", v, old);

    // transfer in the same clock as the low-byte read
    rd(A_CAPH, v);
    drive_in(0); idle(4);
    drive_in(1); @(negedge clk);
    rd(A_CAPL, v); check("R7 low read returns old byte", v, old & 8'hff);
    rd_cap(v);
    check("R7 transfer not blocked", v != old, 1);
    check("R7 value vs model", v, m_cap);

    // interrupt gating
    wr(A_CTRL, 3); idle(1);
    check("R9 irq with flag and enable", cap_irq, 1);
    rd(A_STAT, v); rd(A_CAPL, v); idle(1);
    check("R9 irq after clear", cap_irq, 0);

    // map
    rd(A_CTRL, v); check("R8 ctrl readback", v, 3);
    wr('h1f, 8'hff);
    rd(A_CTRL, v); check("R8 write elsewhere ignored", v, 3);
    rd('h1f, v); check("R8 unmapped read", v, 0);
    rd('h10, v); check("R8 unmapped read low", v, 0);

    idle(2);
    done = 1;
    summary();
    $finish;
  end
endmodule